// File: doc/BRIEF.md
# I2C Bus Presence Scanner

This block sweeps an I2C bus once for each start request and reports which 7-bit addresses have a device that answers. It is a bus master with its own bit sequencer and drives the two lines in open-drain form. Each `*Oe` output pulls its line low when high. The `*In` inputs read the wired level of each line. For every address in the probed range the block does the following:

- waits for the bus to be quiet;
- issues a START;
- shifts out the address with a write direction bit;
- samples the acknowledge slot;
- closes with a STOP.

An address that acknowledged sets its bit in a 128-bit presence map, and a device count rises with it. A one-cycle done pulse marks the end of the sweep. The results then stay unchanged until the next accepted start. The block is meant as a helper for power-on self-test. It tells firmware which devices exist without reading any of them.

Timing runs on a quarter-bit timer of `QTR_CYCLES` system clocks. Addresses `0x00`–`0x07` and `0x78`–`0x7F` are treated as reserved and never probed. If another master wins the bus in the middle of a probe, the block backs off and repeats the same address. A slave that holds SCL low stretches the bit as long as it likes.

Top module: `i2cAddrScanner`

## Requirements
- R1: While reset is held and after it is released, `presenceMap` is all zero, `devCount` is 0, `scanDone` is low and both `sclOe` and `sdaOe` are low (lines released).
- R2: Each probe consists of the following steps, in order:
  - a START, with SDA falling while SCL is high;
  - eight bits sent MSB first with SDA changing only while SCL is low: the 7-bit address followed by a direction bit of 0 (write);
  - a ninth clock during which the block releases SDA;
  - a STOP, with SDA rising while SCL is high.
- R3: A sweep probes addresses 0x08 through 0x77 in ascending order, one completed probe per address. Addresses 0x00–0x07 and 0x78–0x7F are never put on the wire, and their map bits stay 0.
- R4: Map bit `a` is set at the end of a sweep exactly when SDA was low at the ninth-clock sample of the probe of address `a`. `devCount` always equals the number of set map bits.
- R5: A start request accepted while the block is idle clears the map and the count before the first probe.
- R6: `scanDone` is high for exactly one cycle, after the STOP of the probe of 0x77. Map and count keep their values from then until the next accepted start.
- R7: A start request that arrives while a sweep is running has no effect. The sweep is not restarted, and the map is not cleared.
- R8: If SDA reads low at the sample point of an address bit the block sent as 1, the block does three things:
  - it releases both lines;
  - it waits for the bus to be idle;
  - it probes the same address again from the START.
- R9: After releasing SCL, the block holds off the high-phase timing until SCL actually reads high. A slave that stretches the clock therefore delays the ACK sample instead of losing it.
- R10: Before every START both lines have read high for at least `IDLE_CYCLES` consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startScan | input | 1 | Request a sweep (taken only when idle) |
| sclIn | input | 1 | Wired level of SCL |
| sdaIn | input | 1 | Wired level of SDA |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| presenceMap | output | 128 | Bit `a` set when address `a` acknowledged |
| devCount | output | 8 | Number of acknowledging addresses |
| scanDone | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The first sweep runs against a populated bus that includes both probed boundaries (0x08 and 0x77), devices parked at reserved addresses, and a clock-stretching slave that acknowledges only after a long hold. This separates correct range limits and stretch handling from a block that samples on its own timer. In the same sweep a rival master pulls SDA during one address. The retry then has to reappear on the wire, which distinguishes backing off from pressing on. The second sweep uses a different population and a start request in the middle, which exposes any clearing or restarting. The third sweep runs on an empty bus, where every probe must read NACK.

// File: rtl/i2cScanPkg.sv
package i2cScanPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITBUS,
    ST_START,
    ST_BIT,
    ST_STOP,
    ST_DONE
  } scanStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;   // restart sweep: first address, empty map
    logic loadByte;   // load {address, write bit} into shifter
    logic shiftByte;  // advance to next bit
    logic markAck;    // record current address as present
    logic stepAddr;   // move to next address
  } scanCtlT;

endpackage

// File: rtl/i2cScanDatapath.sv
module i2cScanDatapath
  import i2cScanPkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int FIRST_ADDR = 8,
  parameter int LAST_ADDR  = 119
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  scanCtlT                ctl,
  output logic                   txBit,
  output logic                   atLast,
  output logic [(2**ADDR_W)-1:0] presenceMap,
  output logic [ADDR_W:0]        devCount
);

  localparam int MAP_W = 2 ** ADDR_W;
  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(FIRST_ADDR);
  localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(LAST_ADDR);

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W:0]   shiftReg;
  logic [MAP_W-1:0]  hitVec;

  // one-hot decode of the current address, qualified by the ack strobe
  for (genvar i = 0; i < MAP_W; i++) begin : g_hit
    assign hitVec[i] = ctl.markAck && (curAddr == ADDR_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr     <= FIRST_A;
      shiftReg    <= '1;
      presenceMap <= '0;
      devCount    <= '0;
    end else begin
      if (ctl.clearAll) begin
        curAddr     <= FIRST_A;
        presenceMap <= '0;
        devCount    <= '0;
      end else begin
        if (ctl.stepAddr) curAddr <= curAddr + 1'b1;
        if (ctl.markAck) begin
          presenceMap <= presenceMap | hitVec;
          devCount    <= devCount + 1'b1;
        end
      end
      // ones shift in behind the byte so the ack slot leaves SDA released
      if (ctl.loadByte)       shiftReg <= {curAddr, 1'b0};
      else if (ctl.shiftByte) shiftReg <= {shiftReg[ADDR_W-1:0], 1'b1};
    end
  end

  assign txBit  = shiftReg[ADDR_W];
  assign atLast = (curAddr == LAST_A);

endmodule

// File: rtl/i2cScanControl.sv
module i2cScanControl
  import i2cScanPkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int QTR_CYCLES  = 4,
  parameter int IDLE_CYCLES = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startScan,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    txBit,
  input  logic    atLast,
  output scanCtlT ctl,
  output logic    sclOe,
  output logic    sdaOe,
  output logic    scanDone
);

  localparam int TICK_W = $clog2(QTR_CYCLES + 1);
  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
  localparam int BIT_W  = $clog2(ADDR_W + 2);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(QTR_CYCLES - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_CYCLES - 1);
  localparam logic [BIT_W-1:0]  ACK_BIT   = BIT_W'(ADDR_W + 1);

  scanStateT         state, stateNxt;
  logic [1:0]        quarter, quarterNxt;
  logic [TICK_W-1:0] tickCnt, tickNxt;
  logic [IDLE_W-1:0] idleCnt, idleNxt;
  logic [BIT_W-1:0]  bitIdx, bitNxt;
  logic              stall, tickEnd;

  // SCL released but still low: a slave is stretching
  assign stall   = (state == ST_BIT || state == ST_STOP) && quarter == 2'd1 && !sclIn;
  assign tickEnd = (tickCnt == TICK_LAST) && !stall;

  always_comb begin
    stateNxt   = state;
    quarterNxt = quarter;
    tickNxt    = tickCnt;
    idleNxt    = idleCnt;
    bitNxt     = bitIdx;
    ctl        = '0;
    unique case (state)
      ST_IDLE: begin
        if (startScan) begin
          ctl.clearAll = 1'b1;
          stateNxt     = ST_WAITBUS;
          idleNxt      = '0;
        end
      end
      ST_WAITBUS: begin
        if (sclIn && sdaIn) begin
          if (idleCnt == IDLE_LAST) begin
            ctl.loadByte = 1'b1;
            stateNxt     = ST_START;
            quarterNxt   = 2'd0;
            tickNxt      = '0;
          end else begin
            idleNxt = idleCnt + 1'b1;
          end
        end else begin
          idleNxt = '0;
        end
      end
      ST_START, ST_BIT, ST_STOP: begin
        if (stall) begin
          tickNxt = '0;
        end else if (!tickEnd) begin
          tickNxt = tickCnt + 1'b1;
        end else begin
          tickNxt = '0;
          if (state == ST_START) begin
            if (quarter == 2'd2) begin
              stateNxt   = ST_BIT;
              quarterNxt = 2'd0;
              bitNxt     = '0;
            end else begin
              quarterNxt = quarter + 1'b1;
            end
          end else if (state == ST_BIT) begin
            if (quarter == 2'd2) begin
              quarterNxt = 2'd3;
              if (bitIdx == ACK_BIT) begin
                ctl.markAck = !sdaIn;
              end else if (txBit && !sdaIn) begin
                // lost the bus: release and start over on this address
                stateNxt   = ST_WAITBUS;
                idleNxt    = '0;
                quarterNxt = 2'd0;
              end
            end else if (quarter == 2'd3) begin
              quarterNxt = 2'd0;
              if (bitIdx == ACK_BIT) begin
                stateNxt = ST_STOP;
              end else begin
                ctl.shiftByte = 1'b1;
                bitNxt        = bitIdx + 1'b1;
              end
            end else begin
              quarterNxt = quarter + 1'b1;
            end
          end else begin
            if (quarter == 2'd3) begin
              quarterNxt = 2'd0;
              if (atLast) begin
                stateNxt = ST_DONE;
              end else begin
                ctl.stepAddr = 1'b1;
                stateNxt     = ST_WAITBUS;
                idleNxt      = '0;
              end
            end else begin
              quarterNxt = quarter + 1'b1;
            end
          end
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      quarter <= 2'd0;
      tickCnt <= '0;
      idleCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNxt;
      quarter <= quarterNxt;
      tickCnt <= tickNxt;
      idleCnt <= idleNxt;
      bitIdx  <= bitNxt;
    end
  end

  // line drive, decoded from registered state only
  always_comb begin
    sclOe = 1'b0;
    sdaOe = 1'b0;
    unique case (state)
      ST_START: begin
        sdaOe = (quarter != 2'd0);
        sclOe = (quarter == 2'd2);
      end
      ST_BIT: begin
        sclOe = (quarter == 2'd0) || (quarter == 2'd3);
        sdaOe = !txBit;
      end
      ST_STOP: begin
        sclOe = (quarter == 2'd0);
        sdaOe = (quarter == 2'd0) || (quarter == 2'd1);
      end
      default: begin
        sclOe = 1'b0;
        sdaOe = 1'b0;
      end
    endcase
  end

  assign scanDone = (state == ST_DONE);

endmodule

// File: rtl/i2cAddrScanner.sv
module i2cAddrScanner
  import i2cScanPkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int FIRST_ADDR  = 8,
  parameter int LAST_ADDR   = 119,
  parameter int QTR_CYCLES  = 4,
  parameter int IDLE_CYCLES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startScan,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sclOe,
  output logic                   sdaOe,
  output logic [(2**ADDR_W)-1:0] presenceMap,
  output logic [ADDR_W:0]        devCount,
  output logic                   scanDone
);

  scanCtlT ctl;
  logic    txBit;
  logic    atLast;

  i2cScanControl #(
    .ADDR_W(ADDR_W), .QTR_CYCLES(QTR_CYCLES), .IDLE_CYCLES(IDLE_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startScan(startScan),
    .sclIn(sclIn), .sdaIn(sdaIn), .txBit(txBit), .atLast(atLast),
    .ctl(ctl), .sclOe(sclOe), .sdaOe(sdaOe), .scanDone(scanDone)
  );

  i2cScanDatapath #(
    .ADDR_W(ADDR_W), .FIRST_ADDR(FIRST_ADDR), .LAST_ADDR(LAST_ADDR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txBit(txBit), .atLast(atLast),
    .presenceMap(presenceMap), .devCount(devCount)
  );

endmodule

// File: rtl/i2cScanChecker.sv
module i2cScanChecker #(
  parameter int ADDR_W     = 7,
  parameter int FIRST_ADDR = 8,
  parameter int LAST_ADDR  = 119
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   startScan,
  input logic                   scanDone,
  input logic [(2**ADDR_W)-1:0] presenceMap,
  input logic [ADDR_W:0]        devCount
);

  localparam int MAP_W = 2 ** ADDR_W;

  function automatic logic [MAP_W-1:0] reservedMask();
    logic [MAP_W-1:0] m;
    for (int i = 0; i < MAP_W; i++) m[i] = (i < FIRST_ADDR) || (i > LAST_ADDR);
    return m;
  endfunction

  localparam logic [MAP_W-1:0] RES_MASK = reservedMask();

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

  // R4
  count_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    devCount == ($bits(devCount))'($countones(presenceMap)));

  // R3
  reserved_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (presenceMap & RES_MASK) == '0);

  // R6
  post_done_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (scanDone && !startScan) |=> ($stable(presenceMap) && $stable(devCount)));

endmodule

bind i2cAddrScanner i2cScanChecker #(
  .ADDR_W(ADDR_W), .FIRST_ADDR(FIRST_ADDR), .LAST_ADDR(LAST_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .startScan(startScan), .scanDone(scanDone),
  .presenceMap(presenceMap), .devCount(devCount)
);

// File: tb/i2cAddrScanner_tb_top.sv
`timescale 1ns/1ps
module i2cAddrScanner_tb_top;

  localparam int QTR = 4;
  localparam int IDLE = 8;
  localparam int FIRST = 8;
  localparam int LAST = 119;
  localparam int STRETCH = 30;
  localparam int RIVAL_HOLD = 40;
  localparam int RIVAL_ADDR = 'h2A;
  localparam int SLOW_ADDR = 'h50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startScan = 1'b0;
  logic slvScl = 1'b0, slvSda = 1'b0, rivalSda = 1'b0;
  logic sclOe, sdaOe, scanDone;
  logic [127:0] presenceMap;
  logic [7:0] devCount;
  logic sclLine, sdaLine;

  assign sclLine = !(sclOe || slvScl);
  assign sdaLine = !(sdaOe || slvSda || rivalSda);

  always #4 clk = !clk;

  i2cAddrScanner #(.QTR_CYCLES(QTR), .IDLE_CYCLES(IDLE)) dut_i (
    .clk(clk), .rstN(rstN), .startScan(startScan), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .presenceMap(presenceMap), .devCount(devCount),
    .scanDone(scanDone)
  );

  int checks = 0, errors = 0;
  bit present[128];
  int expQ[$];
  logic [127:0] expMap = '0;
  int expCount = 0;
  bit resultsValid = 1'b0, inSweep = 1'b0, sweepEnded = 1'b0;
  bit rivalEnable = 1'b0, rivalUsed = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // behavioural slave population, rival master and bus monitor
  initial begin
    bit prevScl = 1'b1, prevSda = 1'b1, active = 1'b0;
    int bitCnt = 0, stretchCnt = 0, rivalTimer = 0, highRun = 0;
    logic [7:0] shiftB = '0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        automatic bit sclNow = sclLine;
        automatic bit sdaNow = sdaLine;
        if (prevScl && sclNow && prevSda && !sdaNow) begin
          check(highRun >= IDLE, "R10 idle run before START", highRun, IDLE);
          active = 1'b1; bitCnt = 0; shiftB = '0;
        end else if (prevScl && sclNow && !prevSda && sdaNow) begin
          active = 1'b0;
        end else if (active && !prevScl && sclNow && bitCnt < 8) begin
          shiftB = {shiftB[6:0], sdaNow};
          bitCnt++;
        end else if (active && prevScl && !sclNow) begin
          if (bitCnt == 8) begin
            automatic int a = int'(shiftB[7:1]);
            check(shiftB[0] == 1'b0, "R2 direction bit is write", shiftB[0], 0);
            if (expQ.size() == 0) check(1'b0, "R3 unexpected probe", a, 0);
            else begin
              automatic int e = expQ.pop_front();
              check(a == e, "R3 probe address order", a, e);
            end
            if (present[a]) begin
              if (a == SLOW_ADDR) begin slvScl = 1'b1; stretchCnt = STRETCH; end
              else slvSda = 1'b1;
            end
            bitCnt = 9;
          end else if (bitCnt == 9) begin
            slvSda = 1'b0;
            bitCnt = 10;
          end else if (bitCnt == 1 && rivalEnable && !rivalUsed &&
                       expQ.size() > 0 && expQ[0] == RIVAL_ADDR) begin
            rivalSda = 1'b1; rivalTimer = RIVAL_HOLD; rivalUsed = 1'b1;
          end
        end
        if (stretchCnt > 0) begin
          stretchCnt--;
          if (stretchCnt == 3) slvSda = 1'b1;
          if (stretchCnt == 0) slvScl = 1'b0;
        end
        if (rivalTimer > 0) begin
          rivalTimer--;
          if (rivalTimer == 0) rivalSda = 1'b0;
        end
        highRun = (sclNow && sdaNow) ? highRun + 1 : 0;
        prevScl = sclNow; prevSda = sdaNow;
        // per-clock comparison against the reference
        if (scanDone) begin
          check(inSweep, "R6 done only at end of sweep", scanDone, inSweep);
          check(expQ.size() == 0, "R3 every address probed once", expQ.size(), 0);
          check(presenceMap == expMap, "R4 presence map", presenceMap, expMap);
          check(devCount == expCount, "R4 device count", devCount, expCount);
          inSweep = 1'b0; resultsValid = 1'b1; sweepEnded = 1'b1;
        end else if (resultsValid) begin
          check(presenceMap == expMap, "R6 map held after done", presenceMap, expMap);
          check(devCount == expCount, "R6 count held after done", devCount, expCount);
        end
      end
    end
  end

  task automatic runSweep(input bit midStart, input bit checkClear);
    @(posedge clk); #1;
    resultsValid = 1'b0; sweepEnded = 1'b0; inSweep = 1'b1;
    expQ.delete(); expMap = '0; expCount = 0;
    for (int a = FIRST; a <= LAST; a++) begin
      expQ.push_back(a);
      if (present[a]) begin expMap[a] = 1'b1; expCount++; end
    end
    @(negedge clk); startScan = 1'b1;
    @(negedge clk); startScan = 1'b0;
    if (checkClear) begin
      repeat (2) @(negedge clk);
      check(presenceMap == '0, "R5 map cleared on start", presenceMap, 0);
      check(devCount == 0, "R5 count cleared on start", devCount, 0);
    end
    if (midStart) begin
      repeat (3000) @(negedge clk);
      startScan = 1'b1;   // R7 request during a running sweep
      @(negedge clk); startScan = 1'b0;
    end
    while (!sweepEnded) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected sweep completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, during and after reset
    check(presenceMap == '0 && devCount == 0, "R1 results clear in reset", presenceMap, 0);
    check(!scanDone && !sclOe && !sdaOe, "R1 lines released in reset", {scanDone, sclOe, sdaOe}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(!scanDone && !sclOe && !sdaOe && devCount == 0, "R1 idle after reset",
          {scanDone, sclOe, sdaOe, devCount}, 0);

    // sweep 1: boundaries, reserved devices, rival master (R8), stretcher (R9)
    foreach (present[i]) present[i] = 1'b0;
    present['h03] = 1'b1; present['h7A] = 1'b1;
    present['h08] = 1'b1; present['h77] = 1'b1;
    present[RIVAL_ADDR] = 1'b1; present['h3C] = 1'b1; present[SLOW_ADDR] = 1'b1;
    rivalEnable = 1'b1;
    runSweep(1'b0, 1'b0);
    check(rivalUsed, "R8 rival interference injected", rivalUsed, 1);
    check(presenceMap[RIVAL_ADDR], "R8 retried address recorded", presenceMap[RIVAL_ADDR], 1);
    check(presenceMap[SLOW_ADDR], "R9 stretched ack recorded", presenceMap[SLOW_ADDR], 1);
    check(presenceMap['h03] == 0 && presenceMap['h7A] == 0, "R3 reserved bits clear",
          {presenceMap['h03], presenceMap['h7A]}, 0);
    rivalEnable = 1'b0;

    // sweep 2: new population, clear on start (R5), ignored mid start (R7)
    foreach (present[i]) present[i] = 1'b0;
    present['h10] = 1'b1; present['h11] = 1'b1; present['h60] = 1'b1;
    runSweep(1'b1, 1'b1);
    check(devCount == 3, "R7 sweep unaffected by mid request", devCount, 3);

    // sweep 3: empty bus, every probe NACKs
    foreach (present[i]) present[i] = 1'b0;
    runSweep(1'b0, 1'b1);
    check(devCount == 0 && presenceMap == '0, "R4 empty bus", presenceMap, 0);

    summary();
    $finish;
  end

endmodule